// File: doc/BRIEF.md
# 32-Pin GPIO Bank with Dual Interrupt Lines

This block is a bank of 32 general-purpose pins behind a 32-bit register port that also takes byte and halfword accesses. Each pin can be an input or an output. Input pins can raise events on a rising edge, a falling edge, a high level or a low level. Each event is latched into two independent status registers. Each status register has its own enable mask and drives its own interrupt line, so two different processors can serve the same pins.

Enables, wakeup enables and output data each have a pair of write-only-in-effect aliases that set or clear bits atomically. A read of an alias returns the register behind it. A wakeup pulse goes out on an event when the idle-mode bits allow it. A soft reset through the system configuration register returns the bank to its reset state. The debounce registers are stored only; no debounce timing is applied.

Bus protocol: `req_i` high for one cycle at a rising clock edge performs an access. `we_i` selects a write. `size_i` is 0 for a byte, 1 for a halfword and 2 for a word. `addr_i[1:0]` is the byte lane, and write data is right-aligned in `wdata_i`. Read data appears on `rdata_o` after the edge that took the request, and holds until the next read.

Top module: `gpio_bank`

## Requirements
- R1: After reset, these registers read as follows: system config 0, control 2, output enable 0xFFFFFFFF, all enables, wakeup enables, detect and debounce registers 0, and both status registers 0. Both irq lines are low, and the revision register returns the REVISION parameter.
- R2: Word offsets are: 0x00 revision, 0x10 system config, 0x14 system status, 0x18 and 0x28 status of lines 0 and 1, 0x1C and 0x2C enable of lines 0 and 1, 0x20 wakeup enable, 0x30 control, 0x34 output enable (1 = input), 0x38 data in, 0x3C data out, 0x40 low-level detect, 0x44 high-level detect, 0x48 rising detect, 0x4C falling detect, 0x50 debounce enable, 0x54 debounce time (8 bits). Data in returns pin_i as registered one cycle earlier.
- R3: irq_o[k] is high exactly when status k ANDed with enable k is nonzero, and it follows a status or enable change in the cycle after the write or event.
- R4: On an input pin (output enable bit 1), a rising edge with its rising-detect bit set, or a falling edge with its falling-detect bit set, sets that pin's bit in both status registers one clock later. A pin configured as an output raises no event.
- R5: Writing ones to a status register clears those bits. A pin whose level-detect condition still holds (the pin is high with high-detect set, or low with low-detect set) has its bit set again every cycle, so such a bit reads back as 1 after the clear.
- R6: Aliases: 0x60 and 0x64 clear and set enable 0, 0x70 and 0x74 clear and set enable 1, 0x80 and 0x84 clear and set the wakeup enable, 0x90 and 0x94 clear and set data out. A read of an alias returns the underlying register.
- R7: System status always reads 1. Writes to revision, system status and data in have no effect.
- R8: A system config write with bit 1 set performs a soft reset of every register except data out. After any system config write, the stored value is the written value ANDed with 0x1D. A control write keeps only bits 2:0.
- R9: wake_o pulses for one cycle, in the cycle after an event, only when system config bit 2 is set, system config bits 4:3 are nonzero, and the event pin's wakeup enable bit is set.
- R10: pad_o equals data out ANDed with the inverse of output enable, and reflects a write in the cycle after it.
- R11: A byte or halfword write to a plain read/write register replaces only the addressed lanes and keeps the other bytes.
- R12: A byte or halfword write to a status or alias register acts as a word whose unaddressed lanes are zero.
- R13: A read at byte offset n returns the 32-bit register shifted right by 8*n bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Right-aligned write data |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 32 | Pin input levels |
| pad_o | output | 32 | Driven pad values |
| irq_o | output | 2 | Interrupt lines 0 and 1 |
| wake_o | output | 1 | Wakeup pulse |

## Verification
A wrong status or enable bit shows up on irq_o at the first sampling point after the event or write. It also shows in the next status or enable read. A corrupted byte-lane merge shows up in the read-back, and in pad_o in the cycle after the write. This is why pad_o is compared after every randomized output-data or output-enable write. A faulty level re-arm or idle gate is caught within two cycles: by a status read after a clear, or by sampling wake_o one cycle after the pin edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned NLINES = 2;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [7:0] OFS_REV    = 8'h00;
  localparam logic [7:0] OFS_SYSCFG = 8'h10;
  localparam logic [7:0] OFS_SYSST  = 8'h14;
  localparam logic [7:0] OFS_WK     = 8'h20;
  localparam logic [7:0] OFS_CTRL   = 8'h30;
  localparam logic [7:0] OFS_OE     = 8'h34;
  localparam logic [7:0] OFS_DIN    = 8'h38;
  localparam logic [7:0] OFS_DOUT   = 8'h3C;
  localparam logic [7:0] OFS_LLO    = 8'h40;
  localparam logic [7:0] OFS_LHI    = 8'h44;
  localparam logic [7:0] OFS_RDET   = 8'h48;
  localparam logic [7:0] OFS_FDET   = 8'h4C;
  localparam logic [7:0] OFS_DEBEN  = 8'h50;
  localparam logic [7:0] OFS_DEBTM  = 8'h54;
  localparam logic [7:0] OFS_WKCLR  = 8'h80;
  localparam logic [7:0] OFS_WKSET  = 8'h84;
  localparam logic [7:0] OFS_DCLR   = 8'h90;
  localparam logic [7:0] OFS_DSET   = 8'h94;

  localparam logic [7:0] OFS_STAT  [NLINES] = '{8'h18, 8'h28};
  localparam logic [7:0] OFS_EN    [NLINES] = '{8'h1C, 8'h2C};
  localparam logic [7:0] OFS_ENCLR [NLINES] = '{8'h60, 8'h70};
  localparam logic [7:0] OFS_ENSET [NLINES] = '{8'h64, 8'h74};

  localparam logic [DW-1:0] CFG_KEEP   = 32'h0000_001D;
  localparam logic [DW-1:0] CTRL_RESET = 32'h0000_0002;
endpackage

// File: rtl/gpio_lane_merge.sv
module gpio_lane_merge
  import gpio_bank_pkg::*;
(
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    off_i,
  output logic [DW-1:0] merged_o,
  output logic [DW-1:0] raw_o
);
  logic [DW-1:0] base_m;
  logic [DW-1:0] lane_m;

  always_comb begin
    case (size_i)
      SZ_BYTE: base_m = 32'h0000_00FF;
      SZ_HALF: base_m = 32'h0000_FFFF;
      default: base_m = '1;
    endcase
    lane_m   = base_m << {off_i, 3'b000};
    raw_o    = (wdata_i & base_m) << {off_i, 3'b000};
    merged_o = (cur_i & ~lane_m) | raw_o;
  end
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
  import gpio_bank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] pin_i,
  input  logic [DW-1:0] oe_i,
  input  logic [DW-1:0] rdet_i,
  input  logic [DW-1:0] fdet_i,
  input  logic [DW-1:0] llo_i,
  input  logic [DW-1:0] lhi_i,
  output logic [DW-1:0] ev_o,
  output logic [DW-1:0] din_o
);
  logic [DW-1:0] in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= '0;
    else         in_q <= pin_i;
  end

  // level terms are continuous, so a cleared level bit re-arms next cycle
  assign ev_o = oe_i & ((pin_i & ~in_q & rdet_i) | (~pin_i & in_q & fdet_i) |
                        (pin_i & lhi_i) | (~pin_i & llo_i));
  assign din_o = in_q;

  a_r2_din_tracks_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> din_o == $past(pin_i));
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
  import gpio_bank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic [DW-1:0] ev_i,
  input  logic [DW-1:0] clr_i,
  input  logic          en_wr_i,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic [DW-1:0] en_val_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] en_o,
  output logic          irq_o
);
  logic [DW-1:0] stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else if (srst_i) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | ev_i;
      if (en_wr_i)       en_q <= en_val_i;
      else if (en_set_i) en_q <= en_q | en_val_i;
      else if (en_clr_i) en_q <= en_q & ~en_val_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q);

  a_r3_event_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(ev_i & en_q)) && !srst_i && !en_wr_i && !en_clr_i) |=> irq_o);

  a_r5_clear_without_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((stat_o & $past(clr_i & ~ev_i)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter logic [31:0] REVISION = 32'h0000_0031
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [7:0]    addr_i,
  input  logic [1:0]    size_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [31:0]   pin_i,
  output logic [31:0]   pad_o,
  output logic [1:0]    irq_o,
  output logic          wake_o
);
  logic [7:0]    wa;
  logic [1:0]    off;
  logic          wr, rd, srst;
  logic [DW-1:0] rd_word, merged, raw, ev, din;
  logic [DW-1:0] stat_w [NLINES];
  logic [DW-1:0] en_w   [NLINES];
  logic [DW-1:0] cfg_q, ctrl_q, oe_q, dout_q, wk_q;
  logic [DW-1:0] llo_q, lhi_q, rdet_q, fdet_q, deben_q;
  logic [7:0]    debtm_q;
  logic [DW-1:0] rdata_q;
  logic          wake_q;

  assign wa   = {addr_i[7:2], 2'b00};
  assign off  = addr_i[1:0];
  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;
  assign srst = wr && (wa == OFS_SYSCFG) && merged[1];

  gpio_lane_merge u_merge (
    .cur_i(rd_word), .wdata_i(wdata_i), .size_i(size_i), .off_i(off),
    .merged_o(merged), .raw_o(raw)
  );

  gpio_event_detect u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .oe_i(oe_q),
    .rdet_i(rdet_q), .fdet_i(fdet_q), .llo_i(llo_q), .lhi_i(lhi_q),
    .ev_o(ev), .din_o(din)
  );

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    logic          en_wr, en_set, en_clr;
    logic [DW-1:0] clr;
    assign en_wr  = wr && (wa == OFS_EN[k]);
    assign en_set = wr && (wa == OFS_ENSET[k]);
    assign en_clr = wr && (wa == OFS_ENCLR[k]);
    assign clr    = (wr && (wa == OFS_STAT[k])) ? raw : '0;

    gpio_irq_line u_line (
      .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .ev_i(ev), .clr_i(clr),
      .en_wr_i(en_wr), .en_set_i(en_set), .en_clr_i(en_clr),
      .en_val_i(en_wr ? merged : raw),
      .stat_o(stat_w[k]), .en_o(en_w[k]), .irq_o(irq_o[k])
    );
  end

  always_comb begin
    case (wa)
      OFS_REV:                             rd_word = REVISION;
      OFS_SYSCFG:                          rd_word = cfg_q;
      OFS_SYSST:                           rd_word = 32'h1;
      OFS_STAT[0]:                         rd_word = stat_w[0];
      OFS_STAT[1]:                         rd_word = stat_w[1];
      OFS_EN[0], OFS_ENCLR[0], OFS_ENSET[0]: rd_word = en_w[0];
      OFS_EN[1], OFS_ENCLR[1], OFS_ENSET[1]: rd_word = en_w[1];
      OFS_WK, OFS_WKCLR, OFS_WKSET:        rd_word = wk_q;
      OFS_CTRL:                            rd_word = ctrl_q;
      OFS_OE:                              rd_word = oe_q;
      OFS_DIN:                             rd_word = din;
      OFS_DOUT, OFS_DCLR, OFS_DSET:        rd_word = dout_q;
      OFS_LLO:                             rd_word = llo_q;
      OFS_LHI:                             rd_word = lhi_q;
      OFS_RDET:                            rd_word = rdet_q;
      OFS_FDET:                            rd_word = fdet_q;
      OFS_DEBEN:                           rd_word = deben_q;
      OFS_DEBTM:                           rd_word = {24'h0, debtm_q};
      default:                             rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0; ctrl_q <= CTRL_RESET; oe_q <= '1; dout_q <= '0; wk_q <= '0;
      llo_q <= '0; lhi_q <= '0; rdet_q <= '0; fdet_q <= '0;
      deben_q <= '0; debtm_q <= '0;
    end else if (srst) begin
      cfg_q <= merged & CFG_KEEP; ctrl_q <= CTRL_RESET; oe_q <= '1; wk_q <= '0;
      llo_q <= '0; lhi_q <= '0; rdet_q <= '0; fdet_q <= '0;
      deben_q <= '0; debtm_q <= '0;
    end else if (wr) begin
      case (wa)
        OFS_SYSCFG: cfg_q   <= merged & CFG_KEEP;
        OFS_WK:     wk_q    <= merged;
        OFS_WKCLR:  wk_q    <= wk_q & ~raw;
        OFS_WKSET:  wk_q    <= wk_q | raw;
        OFS_CTRL:   ctrl_q  <= merged & 32'h7;
        OFS_OE:     oe_q    <= merged;
        OFS_DOUT:   dout_q  <= merged;
        OFS_DCLR:   dout_q  <= dout_q & ~raw;
        OFS_DSET:   dout_q  <= dout_q | raw;
        OFS_LLO:    llo_q   <= merged;
        OFS_LHI:    lhi_q   <= merged;
        OFS_RDET:   rdet_q  <= merged;
        OFS_FDET:   fdet_q  <= merged;
        OFS_DEBEN:  deben_q <= merged;
        OFS_DEBTM:  debtm_q <= merged[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      wake_q  <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_word >> {off, 3'b000};
      wake_q <= (|(ev & wk_q)) & cfg_q[2] & (|cfg_q[4:3]);
    end
  end

  assign rdata_o = rdata_q;
  assign wake_o  = wake_q;
  assign pad_o   = dout_q & ~oe_q;

  a_r7_sysstatus_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFS_SYSST) |=> rdata_o == 32'h1);

  a_r9_wake_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(cfg_q[2] && (cfg_q[4:3] != 2'b00)));

  a_r8_softreset_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (ctrl_q == CTRL_RESET) && (oe_q == '1) && ((cfg_q & ~CFG_KEEP) == '0));

  a_r10_pad_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DOUT && size_i == 2'd2) |=> pad_o == ($past(wdata_i) & ~oe_q));
endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam logic [31:0] REV = 32'h0000_0031;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin = '0;
  logic [31:0] pad;
  logic [1:0]  irq;
  logic        wake;

  int n_chk = 0;
  int n_fail = 0;

  gpio_bank #(.REVISION(REV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin),
    .pad_o(pad), .irq_o(irq), .wake_o(wake)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] lmask(input logic [1:0] sz, input logic [1:0] o);
    logic [31:0] b;
    b = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    return b << (8 * o);
  endfunction

  function automatic logic [31:0] shv(input logic [31:0] d, input logic [1:0] sz, input logic [1:0] o);
    logic [31:0] b;
    b = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    return (d & b) << (8 * o);
  endfunction

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; size = sz; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; size = sz;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, 2'd2, d);
    chk(tag, d, exp);
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pin[idx] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d, m_dout, m_oe, v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 rev", 8'h00, REV);
    rd_chk("R1 cfg", 8'h10, 32'h0);
    rd_chk("R1 ctrl", 8'h30, 32'h2);
    rd_chk("R1 oe", 8'h34, 32'hFFFF_FFFF);
    rd_chk("R1 stat0", 8'h18, 32'h0);
    rd_chk("R1 en1", 8'h2C, 32'h0);
    rd_chk("R1 rdet", 8'h48, 32'h0);
    chk("R1 irq", {30'h0, irq}, 32'h0);
    chk("R10 pad reset", pad, 32'h0);
    rd_chk("R7 sysstatus", 8'h14, 32'h1);

    // R4 rising edge event, both status registers
    bus_wr(8'h64, 2'd2, 32'h1);
    bus_wr(8'h48, 2'd2, 32'h1);
    rd_chk("R6 set alias reads en0", 8'h64, 32'h1);
    set_pin(0, 1'b1);
    chk("R3 irq0 after rise", {31'h0, irq[0]}, 32'h1);
    chk("R3 irq1 masked", {31'h0, irq[1]}, 32'h0);
    rd_chk("R4 stat1 rise", 8'h28, 32'h1);
    bus_wr(8'h2C, 2'd2, 32'h1);
    chk("R3 irq1 on enable", {31'h0, irq[1]}, 32'h1);
    bus_wr(8'h70, 2'd2, 32'h1);
    chk("R3 irq1 on clear alias", {31'h0, irq[1]}, 32'h0);
    rd_chk("R6 clear alias reads en1", 8'h70, 32'h0);
    bus_wr(8'h18, 2'd2, 32'h1);
    chk("R5 irq0 after status clear", {31'h0, irq[0]}, 32'h0);
    rd_chk("R5 stat0 cleared", 8'h18, 32'h0);

    // R4 falling edge
    bus_wr(8'h4C, 2'd2, 32'h2);
    set_pin(1, 1'b1);
    rd_chk("R4 no event without detect", 8'h18, 32'h0);
    set_pin(1, 1'b0);
    rd_chk("R4 fall", 8'h18, 32'h2);
    bus_wr(8'h18, 2'd2, 32'h2);

    // R5 level re-arm
    bus_wr(8'h44, 2'd2, 32'h4);
    set_pin(2, 1'b1);
    bus_wr(8'h18, 2'd2, 32'h4);
    rd_chk("R5 level re-set", 8'h18, 32'h4);
    set_pin(2, 1'b0);
    bus_wr(8'h18, 2'd2, 32'h4);
    rd_chk("R5 level gone", 8'h18, 32'h0);

    // R4 output pin raises nothing
    bus_wr(8'h34, 2'd2, 32'hFFFF_FFF7);
    bus_wr(8'h48, 2'd2, 32'h9);
    set_pin(3, 1'b1);
    rd_chk("R4 output pin quiet", 8'h18, 32'h0);

    // R9 wakeup
    bus_wr(8'h10, 2'd2, 32'h0C);
    rd_chk("R8 cfg store", 8'h10, 32'h0C);
    bus_wr(8'h84, 2'd2, 32'h30);
    bus_wr(8'h48, 2'd2, 32'h31);
    set_pin(4, 1'b1);
    chk("R9 wake pulse", {31'h0, wake}, 32'h1);
    @(negedge clk);
    chk("R9 wake one cycle", {31'h0, wake}, 32'h0);
    bus_wr(8'h10, 2'd2, 32'h04);
    set_pin(5, 1'b1);
    chk("R9 no wake idle bits zero", {31'h0, wake}, 32'h0);
    bus_wr(8'h80, 2'd2, 32'h20);
    rd_chk("R6 wk clear", 8'h84, 32'h10);

    // R8 control mask and soft reset
    bus_wr(8'h30, 2'd2, 32'hFF);
    rd_chk("R8 ctrl 3 bits", 8'h30, 32'h7);
    bus_wr(8'h10, 2'd2, 32'h1F);
    rd_chk("R8 cfg after srst", 8'h10, 32'h1D);
    rd_chk("R8 ctrl after srst", 8'h30, 32'h2);
    rd_chk("R8 en0 after srst", 8'h1C, 32'h0);
    rd_chk("R8 rdet after srst", 8'h48, 32'h0);
    rd_chk("R8 stat0 after srst", 8'h18, 32'h0);
    rd_chk("R8 oe after srst", 8'h34, 32'hFFFF_FFFF);
    bus_wr(8'h10, 2'd2, 32'h0);

    // R7 read-only registers and data in
    bus_wr(8'h14, 2'd2, 32'h0);
    bus_wr(8'h00, 2'd2, 32'h0);
    bus_wr(8'h38, 2'd2, 32'h0);
    rd_chk("R7 sysstatus after write", 8'h14, 32'h1);
    rd_chk("R7 rev after write", 8'h00, REV);
    rd_chk("R2 data in", 8'h38, pin);

    // R11 sub-word merge, R13 sub-word reads
    bus_wr(8'h50, 2'd2, 32'h1122_3344);
    bus_wr(8'h51, 2'd0, 32'hAA);
    rd_chk("R11 byte merge", 8'h50, 32'h1122_AA44);
    bus_wr(8'h52, 2'd1, 32'hBEEF);
    rd_chk("R11 half merge", 8'h50, 32'hBEEF_AA44);
    bus_rd(8'h53, 2'd0, d);
    chk("R13 read offset 3", d, 32'h0000_00BE);
    bus_rd(8'h52, 2'd1, d);
    chk("R13 read offset 2", d, 32'h0000_BEEF);

    // R12 sub-word alias writes
    bus_wr(8'h95, 2'd0, 32'h01);
    rd_chk("R12 set alias byte", 8'h3C, 32'h0000_0100);
    bus_wr(8'h1C, 2'd2, 32'hFFFF_FFFF);
    bus_wr(8'h61, 2'd0, 32'hFF);
    rd_chk("R12 clear alias byte", 8'h1C, 32'hFFFF_00FF);

    // R10 random output traffic
    m_dout = 32'h0000_0100;
    m_oe   = 32'hFFFF_FFFF;
    for (int i = 0; i < 300; i++) begin
      logic [1:0] sz, o, op;
      logic [7:0] base;
      op = 2'($urandom % 4);
      sz = 2'($urandom % 3);
      o  = (sz == 2'd2) ? 2'd0 : (sz == 2'd1) ? {1'b0, 1'($urandom % 2)} << 1 : 2'($urandom % 4);
      v  = $urandom;
      case (op)
        2'd0: begin base = 8'h3C; m_dout = (m_dout & ~lmask(sz, o)) | shv(v, sz, o); end
        2'd1: begin base = 8'h94; m_dout = m_dout | shv(v, sz, o); end
        2'd2: begin base = 8'h90; m_dout = m_dout & ~shv(v, sz, o); end
        default: begin base = 8'h34; m_oe = (m_oe & ~lmask(sz, o)) | shv(v, sz, o); end
      endcase
      bus_wr(base + {6'h0, o}, sz, v);
      chk("R10 pad random", pad, m_dout & ~m_oe);
      if (i % 60 == 0) rd_chk("R11 dout random", 8'h3C, m_dout);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule